// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block sits between a status-queue write strobe and the host interrupt line. Its job is to batch interrupts raised by status-queue writes, so the host is interrupted fewer times. It has two holdoff paths, and each has its own enable. The first is an interval timer: a saturating tick counter is compared against a programmable alarm value. The second is a write-event counter with a programmable threshold. When both paths are enabled they work side by side, and whichever path opens its window first releases the pending status-queue interrupt.

Every other interrupt cause arrives on a generic vector. These causes bypass the holdoff logic and drive the active-low output directly. Software loads the alarm, the tick counter and the event threshold through write strobes with data. The tick counter can be read back. A status-read strobe acknowledges the pending status-queue interrupt and restarts the event count.

Top module: `irq_coalesce_top`

## Requirements
- R1: Whenever any bit of `other_irq_i` is high, `irq_n_o` is low in that same cycle, whatever the enables and pending state are.
- R2: The interrupt output is active low. After reset, `irq_n_o` is high, the tick counter reads 0, no status-queue interrupt is pending, the event count is 0, the alarm is 0 and the threshold is 0.
- R3: A status-queue write sets a pending flag from the next cycle. The flag stays set until a status-read strobe clears it. If a write and a read arrive in the same cycle, the flag stays set.
- R4: With both holdoff enables low, a status-queue write drives `irq_n_o` low from the cycle after the write.
- R5: The tick counter adds 1 on each cycle where `tick_i` is high and stops at all-ones instead of wrapping. A counter write loads `clk_wdata_i` and takes priority over a tick. `clock_val_o` always shows the counter.
- R6: With only the timer enabled, a pending status-queue interrupt reaches the output only while the tick counter is strictly greater than the alarm. Equality keeps it held off.
- R7: With only the event path enabled, each status-queue write adds 1 to the event count. The window opens once the count is equal to or greater than the threshold, and a threshold of 0 opens it at once.
- R8: A status-read strobe clears the event count, so the full threshold of writes is needed again before the event window reopens.
- R9: With both paths enabled, the pending interrupt is released as soon as either the timer window or the event window is open.
- R10: The event count stops at the threshold and does not wrap, so the window stays open through any number of further writes until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock-enable tick for the tick counter |
| sq_wr_i | input | 1 | Status-queue write event strobe |
| other_irq_i | input | NUM_OTHER | Interrupt causes that are never delayed |
| timer_en_i | input | 1 | Enables the timer holdoff path |
| event_en_i | input | 1 | Enables the event-count holdoff path |
| alarm_wr_i | input | 1 | Strobe that loads the alarm value |
| alarm_wdata_i | input | TIME_W | Alarm value to load |
| clk_wr_i | input | 1 | Strobe that loads the tick counter |
| clk_wdata_i | input | TIME_W | Tick counter value to load |
| thresh_wr_i | input | 1 | Strobe that loads the event threshold |
| thresh_wdata_i | input | EVT_W | Event threshold to load |
| stat_rd_i | input | 1 | Status-read acknowledge strobe |
| clock_val_o | output | TIME_W | Current tick counter value |
| irq_n_o | output | 1 | Host interrupt, active low |

## Verification
The case hardest to reach from the ports is the saturation of the event counter. A counter that wraps would only show its fault after 2^EVT_W writes, and at that point the window would close with no warning. The stimulus sets a small threshold and sends more than 256 writes without a read, checking the output after every write. The strict greater-than rule of the timer is also pinned down: the tick counter is loaded to exactly the alarm value, and the bench checks that the output stays high until one more tick arrives.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;

  typedef struct packed {
    logic timer_en;
    logic event_en;
  } holdoff_en_t;

  // Release rule: no path enabled means no holdoff; otherwise any open
  // enabled path is enough.
  function automatic logic window_open(input holdoff_en_t en,
                                       input logic timer_open,
                                       input logic event_open);
    logic bypass;
    bypass = !en.timer_en && !en.event_en;
    return bypass || (en.timer_en && timer_open) || (en.event_en && event_open);
  endfunction

  function automatic logic irq_active(input logic pend,
                                      input logic win,
                                      input logic any_other);
    return (pend && win) || any_other;
  endfunction

endpackage

// File: rtl/irq_interval_timer.sv
module irq_interval_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clk_wr_i,
  input  logic [TIME_W-1:0] clk_wdata_i,
  input  logic              alarm_wr_i,
  input  logic [TIME_W-1:0] alarm_wdata_i,
  output logic [TIME_W-1:0] clock_o,
  output logic              open_o
);
  localparam logic [TIME_W-1:0] TMAX = '1;

  function automatic logic [TIME_W-1:0] sat_step(input logic [TIME_W-1:0] v);
    return (v == TMAX) ? v : v + 1'b1;
  endfunction

  function automatic logic past_alarm(input logic [TIME_W-1:0] c,
                                      input logic [TIME_W-1:0] a);
    return c > a;
  endfunction

  logic [TIME_W-1:0] clock_q, alarm_q;
  logic              clock_at_max;

  assign clock_at_max = (clock_q == TMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clock_q <= '0;
    end else if (clk_wr_i) begin
      clock_q <= clk_wdata_i;
    end else if (tick_i) begin
      clock_q <= sat_step(clock_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '0;
    else if (alarm_wr_i) alarm_q <= alarm_wdata_i;
  end

  assign clock_o = clock_q;
  assign open_o  = past_alarm(clock_q, alarm_q);

  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clock_at_max && tick_i && !clk_wr_i) |=> clock_at_max);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_wr_i |=> (clock_q == $past(clk_wdata_i)));

  p_equal_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clock_q == alarm_q) |-> !open_o);

endmodule

// File: rtl/irq_event_window.sv
module irq_event_window #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_wr_i,
  input  logic             stat_rd_i,
  input  logic             thresh_wr_i,
  input  logic [EVT_W-1:0] thresh_wdata_i,
  output logic             open_o
);
  function automatic logic [EVT_W-1:0] bounded_step(input logic [EVT_W-1:0] c,
                                                    input logic [EVT_W-1:0] lim);
    return (c < lim) ? c + 1'b1 : c;
  endfunction

  logic [EVT_W-1:0] cnt_q, thresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thresh_q <= '0;
    else if (thresh_wr_i) thresh_q <= thresh_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stat_rd_i) begin
      cnt_q <= '0;
    end else if (sq_wr_i) begin
      cnt_q <= bounded_step(cnt_q, thresh_q);
    end
  end

  assign open_o = (cnt_q >= thresh_q);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i |=> (cnt_q == '0));

  p_stays_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !stat_rd_i && !thresh_wr_i) |=> open_o);

  p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd_i) |=> (cnt_q - $past(cnt_q) <= 1));

endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top
  import irq_coalesce_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int EVT_W     = 8,
  parameter int NUM_OTHER = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 sq_wr_i,
  input  logic [NUM_OTHER-1:0] other_irq_i,
  input  logic                 timer_en_i,
  input  logic                 event_en_i,
  input  logic                 alarm_wr_i,
  input  logic [TIME_W-1:0]    alarm_wdata_i,
  input  logic                 clk_wr_i,
  input  logic [TIME_W-1:0]    clk_wdata_i,
  input  logic                 thresh_wr_i,
  input  logic [EVT_W-1:0]     thresh_wdata_i,
  input  logic                 stat_rd_i,
  output logic [TIME_W-1:0]    clock_val_o,
  output logic                 irq_n_o
);
  holdoff_en_t en;
  logic        timer_open, event_open, win_open, any_other, sq_pend_q;

  assign en.timer_en = timer_en_i;
  assign en.event_en = event_en_i;
  assign any_other   = |other_irq_i;

  irq_interval_timer #(.TIME_W(TIME_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .clk_wr_i      (clk_wr_i),
    .clk_wdata_i   (clk_wdata_i),
    .alarm_wr_i    (alarm_wr_i),
    .alarm_wdata_i (alarm_wdata_i),
    .clock_o       (clock_val_o),
    .open_o        (timer_open)
  );

  irq_event_window #(.EVT_W(EVT_W)) u_event (
    .clk            (clk),
    .rst_n          (rst_n),
    .sq_wr_i        (sq_wr_i),
    .stat_rd_i      (stat_rd_i),
    .thresh_wr_i    (thresh_wr_i),
    .thresh_wdata_i (thresh_wdata_i),
    .open_o         (event_open)
  );

  // Write has priority over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_pend_q <= 1'b0;
    else if (sq_wr_i) sq_pend_q <= 1'b1;
    else if (stat_rd_i) sq_pend_q <= 1'b0;
  end

  assign win_open = window_open(en, timer_open, event_open);
  assign irq_n_o  = !irq_active(sq_pend_q, win_open, any_other);

  p_other_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_other |-> !irq_n_o);

  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_pend_q && !stat_rd_i) |=> sq_pend_q);

  p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sq_wr_i |=> sq_pend_q);

  p_nodelay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_pend_q && !timer_en_i && !event_en_i) |-> !irq_n_o);

  p_parallel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_pend_q && ((timer_en_i && timer_open) || (event_en_i && event_open)))
      |-> !irq_n_o);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq_pend_q && !any_other) |-> irq_n_o);

endmodule

// File: tb/irq_coalesce_top_tb_top.sv
module irq_coalesce_top_tb_top;
  localparam int TIME_W = 16;
  localparam int EVT_W  = 8;
  localparam int NOTH   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, sq_wr_i = 0, timer_en_i = 0, event_en_i = 0;
  logic alarm_wr_i = 0, clk_wr_i = 0, thresh_wr_i = 0, stat_rd_i = 0;
  logic [NOTH-1:0]   other_irq_i = '0;
  logic [TIME_W-1:0] alarm_wdata_i = '0, clk_wdata_i = '0;
  logic [EVT_W-1:0]  thresh_wdata_i = '0;
  logic [TIME_W-1:0] clock_val_o;
  logic              irq_n_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_coalesce_top #(.TIME_W(TIME_W), .EVT_W(EVT_W), .NUM_OTHER(NOTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sq_wr_i(sq_wr_i),
    .other_irq_i(other_irq_i), .timer_en_i(timer_en_i), .event_en_i(event_en_i),
    .alarm_wr_i(alarm_wr_i), .alarm_wdata_i(alarm_wdata_i),
    .clk_wr_i(clk_wr_i), .clk_wdata_i(clk_wdata_i),
    .thresh_wr_i(thresh_wr_i), .thresh_wdata_i(thresh_wdata_i),
    .stat_rd_i(stat_rd_i), .clock_val_o(clock_val_o), .irq_n_o(irq_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One-cycle strobe helpers: drive at negedge, release at next negedge.
  task automatic pulse_wr();
    @(negedge clk); sq_wr_i = 1; @(negedge clk); sq_wr_i = 0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); stat_rd_i = 1; @(negedge clk); stat_rd_i = 0;
  endtask
  task automatic pulse_tick();
    @(negedge clk); tick_i = 1; @(negedge clk); tick_i = 0;
  endtask
  task automatic load_clock(input logic [TIME_W-1:0] v);
    @(negedge clk); clk_wr_i = 1; clk_wdata_i = v; @(negedge clk); clk_wr_i = 0;
  endtask
  task automatic load_alarm(input logic [TIME_W-1:0] v);
    @(negedge clk); alarm_wr_i = 1; alarm_wdata_i = v; @(negedge clk); alarm_wr_i = 0;
  endtask
  task automatic load_thresh(input logic [EVT_W-1:0] v);
    @(negedge clk); thresh_wr_i = 1; thresh_wdata_i = v; @(negedge clk); thresh_wr_i = 0;
  endtask

  task automatic t_reset();
    chk("R2 irq idle after reset", irq_n_o, 1);
    chk("R2 clock zero after reset", clock_val_o, 0);
  endtask

  task automatic t_no_holdoff();
    timer_en_i = 0; event_en_i = 0;
    pulse_wr();
    chk("R4 immediate irq", irq_n_o, 0);
    pulse_rd();
    chk("R3 read clears pending", irq_n_o, 1);
    @(negedge clk); sq_wr_i = 1; stat_rd_i = 1;
    @(negedge clk); sq_wr_i = 0; stat_rd_i = 0;
    chk("R3 write wins over read", irq_n_o, 0);
    repeat (3) @(negedge clk);
    chk("R3 pending held", irq_n_o, 0);
    pulse_rd();
    chk("R3 cleared after read", irq_n_o, 1);
  endtask

  task automatic t_other();
    timer_en_i = 1; event_en_i = 0;
    load_alarm(16'd1000); load_clock(16'd0);
    pulse_wr();
    chk("R6 held off", irq_n_o, 1);
    @(negedge clk); other_irq_i = 4'b0100; #1;
    chk("R1 other passes through", irq_n_o, 0);
    other_irq_i = 4'b0000; #1;
    chk("R1 other released", irq_n_o, 1);
    pulse_rd();
    timer_en_i = 0; other_irq_i = 4'b1000; #1;
    chk("R1 other with no pending", irq_n_o, 0);
    other_irq_i = '0;
  endtask

  task automatic t_timer();
    timer_en_i = 1; event_en_i = 0;
    load_alarm(16'd5); load_clock(16'd0);
    pulse_wr();
    chk("R6 closed at clock 0", irq_n_o, 1);
    for (int i = 0; i < 5; i++) pulse_tick();
    chk("R5 clock counts ticks", clock_val_o, 5);
    chk("R6 equal still closed", irq_n_o, 1);
    pulse_tick();
    chk("R6 open when greater", irq_n_o, 0);
    pulse_rd();
    chk("R6 read clears", irq_n_o, 1);
    load_clock(16'hFFFE);
    chk("R5 clock load", clock_val_o, 16'hFFFE);
    pulse_tick();
    pulse_tick();
    chk("R5 clock saturates", clock_val_o, 16'hFFFF);
    pulse_tick();
    chk("R5 clock holds at max", clock_val_o, 16'hFFFF);
    @(negedge clk); tick_i = 1; clk_wr_i = 1; clk_wdata_i = 16'd3;
    @(negedge clk); tick_i = 0; clk_wr_i = 0;
    chk("R5 load beats tick", clock_val_o, 3);
  endtask

  task automatic t_event();
    timer_en_i = 0; event_en_i = 1;
    load_thresh(8'd3); pulse_rd();
    pulse_wr(); pulse_wr();
    chk("R7 two of three closed", irq_n_o, 1);
    pulse_wr();
    chk("R7 threshold reached", irq_n_o, 0);
    pulse_rd();
    chk("R8 read clears irq", irq_n_o, 1);
    pulse_wr();
    chk("R8 count restarted", irq_n_o, 1);
    pulse_rd();
    load_thresh(8'd0);
    pulse_wr();
    chk("R7 zero threshold open", irq_n_o, 0);
    pulse_rd();
  endtask

  task automatic t_event_sat();
    bit ok;
    ok = 1;
    timer_en_i = 0; event_en_i = 1;
    load_thresh(8'd2); pulse_rd();
    for (int i = 1; i <= 300; i++) begin
      pulse_wr();
      if (i >= 2 && irq_n_o !== 1'b0) ok = 0;
    end
    chk("R10 window stays open past wrap", ok, 1);
    pulse_rd();
  endtask

  task automatic t_parallel();
    timer_en_i = 1; event_en_i = 1;
    load_alarm(16'd100); load_clock(16'd0); load_thresh(8'd2); pulse_rd();
    pulse_wr();
    chk("R9 both closed", irq_n_o, 1);
    pulse_wr();
    chk("R9 event opens first", irq_n_o, 0);
    pulse_rd();
    chk("R9 read releases", irq_n_o, 1);
    load_clock(16'd200);
    pulse_wr();
    chk("R9 timer opens alone", irq_n_o, 0);
    pulse_rd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_holdoff();
    t_other();
    t_timer();
    t_event();
    t_event_sat();
    t_parallel();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule